// File: doc/BRIEF.md
# Programmable Almost-Full / Almost-Empty Flag Unit

This unit raises an almost-empty flag and an almost-full flag for a dual-clock FIFO. It does not hold any data. It takes the write pointer and the read pointer, with each pointer already carried into both clock domains. From each pair it forms the fill level, which is the write pointer minus the read pointer modulo twice the depth. It then compares that level with one of two offsets. The almost-full decision is made in the write clock domain and the almost-empty decision in the read clock domain. Each raw result passes through two flops clocked by its own domain's clock before it reaches the flag output.

The two offsets are configured while the full reset is held. A three-bit select input picks one of three sources. The first source is a preset, where both offsets take one of five fixed values. The second is a parallel load, where two strobed words are taken from the write-side data bus. The third is a serial load, where the offsets are shifted in bit by bit on a serial input. A parity-mode input is also sampled at full reset. When it is set, bit 8 of each parallel word is discarded. A partial reset clears the flag pipelines only. It keeps the chosen method, the offsets and the loading progress.

Top module: `fill_threshold_flags`

## Requirements
- R1: While fullRstN is low, both offsets take the preset picked by offsetSel. The preset values are 3'b000=8, 3'b001=16, 3'b010=64, 3'b011=256, and 1024 for any other code. offsetSel is decoded as follows: 3'b101 selects serial loading, 3'b110 and 3'b111 select parallel loading, and every other code keeps the preset.
- R2: The fill level in each domain is (wrPtr - rdPtr) modulo 2^(ADDR_W+1), so the result stays correct when the pointers wrap around.
- R3: The raw almost-empty result is 1 when the read-domain fill (wrPtrR - rdPtrR) is less than or equal to the almost-empty offset.
- R4: The raw almost-full result is 1 when the write-domain fill (wrPtrW - rdPtrW) is greater than or equal to 2^ADDR_W minus the almost-full offset.
- R5: afFlag shows the raw almost-full result from two wrClk rising edges earlier. aeFlag shows the raw almost-empty result from two rdClk rising edges earlier.
- R6: In parallel mode, a wrClk edge with cfgLoad high loads cfgData[ADDR_W-1:0]. The first such edge after full reset writes the almost-empty offset and the second writes the almost-full offset. Any later strobes are ignored.
- R7: When parityMode was high at full reset, cfgData bit 8 is taken as 0 in every parallel load. Otherwise bit 8 is loaded like the other bits.
- R8: In serial mode, each wrClk edge with cfgLoad high shifts in serialIn, most significant bit first. The first ADDR_W bits form the almost-empty offset and the next ADDR_W bits form the almost-full offset. Once 2*ADDR_W bits have been taken, further strobes are ignored.
- R9: On any wrClk edge where fullRstN or partRstN is low, afFlag becomes 0. On any rdClk edge where either reset is low, aeFlag becomes 1.
- R10: While partRstN is low, both offsets, the mode and the loading progress hold their values, and cfgLoad is ignored.
- R11: In preset mode, cfgLoad has no effect on the offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-domain clock |
| rdClk | input | 1 | Read-domain clock |
| fullRstN | input | 1 | Full reset, active low, synchronous in each domain; samples configuration |
| partRstN | input | 1 | Partial reset, active low; clears flag pipelines only |
| offsetSel | input | 3 | Preset / serial / parallel select, sampled during full reset |
| parityMode | input | 1 | Drop data bit 8 on parallel loads, sampled during full reset |
| cfgLoad | input | 1 | Load / shift strobe, write domain |
| cfgData | input | DATA_W | Write-side data bus used for parallel loads |
| serialIn | input | 1 | Serial offset bit |
| wrPtrW | input | ADDR_W+1 | Write pointer, write domain |
| rdPtrW | input | ADDR_W+1 | Read pointer synchronised into write domain |
| wrPtrR | input | ADDR_W+1 | Write pointer synchronised into read domain |
| rdPtrR | input | ADDR_W+1 | Read pointer, read domain |
| aeFlag | output | 1 | Almost-empty flag, read domain |
| afFlag | output | 1 | Almost-full flag, write domain |

## Verification
A pointer change that is present at a domain's rising edge reaches that domain's flag on the second rising edge after it. An offset load takes effect at the write edge that samples the strobe. The read domain therefore sees a new almost-empty offset from its next edge onward. The reference model computes the raw comparison at each edge of its own clock, using the offsets from just before the write edge. It then delays that value through a two-entry queue per domain. Both flags are compared with the model at every wrClk falling edge, which keeps each sample away from the rising edges of both clocks. Single-cycle pointer blips check the two-edge delay directly. Strobes during partial reset and in preset mode are followed by fill sweeps around the expected thresholds, so that any change to a held offset would show at the flag ports.

// File: rtl/ftf_pkg.sv
`timescale 1ns/1ps
package ftf_pkg;

  typedef enum logic [1:0] {
    MODE_PRESET   = 2'd0,
    MODE_SERIAL   = 2'd1,
    MODE_PARALLEL = 2'd2
  } cfgMode_e;

  // strobes from control to datapath, write domain
  typedef struct packed {
    logic takePreset;  // reload both offsets from preset table
    logic loadLow;     // parallel word -> almost-empty offset
    logic loadHigh;    // parallel word -> almost-full offset
    logic shiftIn;     // shift one serial bit through both offsets
  } ofsStrobe_t;

  function automatic int unsigned presetOffset(input logic [2:0] sel);
    case (sel)
      3'b000:  return 8;
      3'b001:  return 16;
      3'b010:  return 64;
      3'b011:  return 256;
      default: return 1024;
    endcase
  endfunction

  function automatic cfgMode_e decodeMode(input logic [2:0] sel);
    case (sel)
      3'b101:          return MODE_SERIAL;
      3'b110, 3'b111:  return MODE_PARALLEL;
      default:         return MODE_PRESET;
    endcase
  endfunction

endpackage

// File: rtl/ftf_sync.sv
`timescale 1ns/1ps
module ftf_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) chain[0] <= RST_VAL;
          else       chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) chain[s] <= RST_VAL;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ftf_ctrl.sv
`timescale 1ns/1ps
module ftf_ctrl
  import ftf_pkg::*;
#(
  parameter int OFS_W = 11
) (
  input  logic       wrClk,
  input  logic       fullRstN,
  input  logic       partRstN,
  input  logic [2:0] offsetSel,
  input  logic       parityMode,
  input  logic       cfgLoad,
  output ofsStrobe_t strobe,
  output logic       parityOn,
  output cfgMode_e   mode
);
  localparam int SHIFT_N = 2 * OFS_W;
  localparam int CNT_W   = $clog2(SHIFT_N + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SHIFT_N);

  logic [CNT_W-1:0] progCnt;
  logic             advance;

  always_comb begin
    strobe = '0;
    strobe.takePreset = !fullRstN;
    if (fullRstN && partRstN && cfgLoad) begin
      unique case (mode)
        MODE_SERIAL:   strobe.shiftIn = (progCnt < CNT_LAST);
        MODE_PARALLEL: begin
          strobe.loadLow  = (progCnt == CNT_W'(0));
          strobe.loadHigh = (progCnt == CNT_W'(1));
        end
        default: ;
      endcase
    end
  end

  assign advance = strobe.shiftIn | strobe.loadLow | strobe.loadHigh;

  always_ff @(posedge wrClk) begin
    if (!fullRstN) begin
      mode     <= decodeMode(offsetSel);
      parityOn <= parityMode;
      progCnt  <= '0;
    end else if (advance) begin
      progCnt  <= progCnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/ftf_path.sv
`timescale 1ns/1ps
module ftf_path
  import ftf_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 36,
  parameter int OFS_W  = ADDR_W,
  parameter int SYNC_N = 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              fullRstN,
  input  logic              partRstN,
  input  logic [2:0]        offsetSel,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              serialIn,
  input  ofsStrobe_t        strobe,
  input  logic              parityOn,
  input  logic [ADDR_W:0]   wrPtrW,
  input  logic [ADDR_W:0]   rdPtrW,
  input  logic [ADDR_W:0]   wrPtrR,
  input  logic [ADDR_W:0]   rdPtrR,
  output logic              aeFlag,
  output logic              afFlag
);
  localparam int PTR_W      = ADDR_W + 1;
  localparam int PARITY_BIT = 8;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1) << ADDR_W;

  logic [OFS_W-1:0] aeOfs, afOfs, loadVal;
  logic [PTR_W-1:0] wrFill, rdFill, afLimit;
  logic             afRaw, aeRaw, flagRstN;

  always_comb begin
    loadVal = cfgData[OFS_W-1:0];
    if (parityOn) loadVal[PARITY_BIT] = 1'b0;
  end

  always_ff @(posedge wrClk) begin
    if (strobe.takePreset) begin
      aeOfs <= OFS_W'(presetOffset(offsetSel));
      afOfs <= OFS_W'(presetOffset(offsetSel));
    end else if (strobe.loadLow) begin
      aeOfs <= loadVal;
    end else if (strobe.loadHigh) begin
      afOfs <= loadVal;
    end else if (strobe.shiftIn) begin
      {aeOfs, afOfs} <= {aeOfs[OFS_W-2:0], afOfs, serialIn};
    end
  end

  // write domain: almost-full
  assign wrFill  = wrPtrW - rdPtrW;
  assign afLimit = DEPTH_P - PTR_W'(afOfs);
  assign afRaw   = (wrFill >= afLimit);

  // read domain: almost-empty
  assign rdFill  = wrPtrR - rdPtrR;
  assign aeRaw   = (rdFill <= PTR_W'(aeOfs));

  assign flagRstN = fullRstN & partRstN;

  ftf_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_afSync (
    .clk(wrClk), .rstN(flagRstN), .d(afRaw), .q(afFlag)
  );

  ftf_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_aeSync (
    .clk(rdClk), .rstN(flagRstN), .d(aeRaw), .q(aeFlag)
  );
endmodule

// File: rtl/fill_threshold_flags.sv
`timescale 1ns/1ps
module fill_threshold_flags
  import ftf_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 36
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              fullRstN,
  input  logic              partRstN,
  input  logic [2:0]        offsetSel,
  input  logic              parityMode,
  input  logic              cfgLoad,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              serialIn,
  input  logic [ADDR_W:0]   wrPtrW,
  input  logic [ADDR_W:0]   rdPtrW,
  input  logic [ADDR_W:0]   wrPtrR,
  input  logic [ADDR_W:0]   rdPtrR,
  output logic              aeFlag,
  output logic              afFlag
);
  localparam int OFS_W = ADDR_W;

  ofsStrobe_t strobe;
  logic       parityOn;
  cfgMode_e   mode;

  ftf_ctrl #(.OFS_W(OFS_W)) u_ctrl (
    .wrClk(wrClk), .fullRstN(fullRstN), .partRstN(partRstN),
    .offsetSel(offsetSel), .parityMode(parityMode), .cfgLoad(cfgLoad),
    .strobe(strobe), .parityOn(parityOn), .mode(mode)
  );

  ftf_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W)) u_path (
    .wrClk(wrClk), .rdClk(rdClk), .fullRstN(fullRstN), .partRstN(partRstN),
    .offsetSel(offsetSel), .cfgData(cfgData), .serialIn(serialIn),
    .strobe(strobe), .parityOn(parityOn),
    .wrPtrW(wrPtrW), .rdPtrW(rdPtrW), .wrPtrR(wrPtrR), .rdPtrR(rdPtrR),
    .aeFlag(aeFlag), .afFlag(afFlag)
  );
endmodule

// File: rtl/ftf_checker.sv
`timescale 1ns/1ps
module ftf_checker #(
  parameter int PTR_W = 12,
  parameter int OFS_W = 11
) (
  input logic             wrClk,
  input logic             rdClk,
  input logic             fullRstN,
  input logic             partRstN,
  input logic             cfgLoad,
  input logic [1:0]       cfgMode,
  input logic [PTR_W-1:0] wrPtrW,
  input logic [PTR_W-1:0] rdPtrW,
  input logic [PTR_W-1:0] wrPtrR,
  input logic [PTR_W-1:0] rdPtrR,
  input logic [OFS_W-1:0] aeOfs,
  input logic [OFS_W-1:0] afOfs,
  input logic             aeFlag,
  input logic             afFlag
);
  localparam int WV = 2 * PTR_W + OFS_W;

  logic [WV-1:0] prevWr, prevRd, curWr, curRd;
  logic [1:0]    wrQuiet, rdQuiet;

  assign curWr = {wrPtrW, rdPtrW, afOfs};
  assign curRd = {wrPtrR, rdPtrR, aeOfs};

  // counts consecutive edges with unchanged compare inputs
  always_ff @(posedge wrClk) begin
    prevWr <= curWr;
    if (!(fullRstN && partRstN) || curWr != prevWr) wrQuiet <= 2'd0;
    else if (wrQuiet != 2'd3)                        wrQuiet <= wrQuiet + 2'd1;
  end

  always_ff @(posedge rdClk) begin
    prevRd <= curRd;
    if (!(fullRstN && partRstN) || curRd != prevRd) rdQuiet <= 2'd0;
    else if (rdQuiet != 2'd3)                        rdQuiet <= rdQuiet + 2'd1;
  end

  assert_af_quiet_R5: assert property (@(posedge wrClk)
    disable iff (!fullRstN || !partRstN) (wrQuiet == 2'd3) |-> $stable(afFlag));

  assert_ae_quiet_R5: assert property (@(posedge rdClk)
    disable iff (!fullRstN || !partRstN) (rdQuiet == 2'd3) |-> $stable(aeFlag));

  assert_af_reset_R9: assert property (@(posedge wrClk)
    disable iff (!fullRstN) !partRstN |=> !afFlag);

  assert_ae_reset_R9: assert property (@(posedge rdClk)
    disable iff (!fullRstN) !partRstN |=> aeFlag);

  assert_cfg_hold_R10: assert property (@(posedge wrClk)
    disable iff (!fullRstN) !partRstN |=> ($stable(aeOfs) && $stable(afOfs)));

  assert_preset_ignore_R11: assert property (@(posedge wrClk)
    disable iff (!fullRstN) (cfgLoad && cfgMode == 2'd0) |=> ($stable(aeOfs) && $stable(afOfs)));
endmodule

bind fill_threshold_flags ftf_checker #(.PTR_W(ADDR_W + 1), .OFS_W(ADDR_W)) u_checker (
  .wrClk(wrClk), .rdClk(rdClk), .fullRstN(fullRstN), .partRstN(partRstN),
  .cfgLoad(cfgLoad), .cfgMode(u_ctrl.mode),
  .wrPtrW(wrPtrW), .rdPtrW(rdPtrW), .wrPtrR(wrPtrR), .rdPtrR(rdPtrR),
  .aeOfs(u_path.aeOfs), .afOfs(u_path.afOfs),
  .aeFlag(aeFlag), .afFlag(afFlag)
);

// File: tb/fill_threshold_flags_bench.sv
`timescale 1ns/1ps
module fill_threshold_flags_bench;
  localparam int ADDR_W = 11;
  localparam int DATA_W = 36;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PMASK  = (2 * DEPTH) - 1;
  localparam int OMASK  = DEPTH - 1;

  logic wrClk = 0, rdClk = 0;
  logic fullRstN, partRstN, parityMode, cfgLoad, serialIn;
  logic [2:0] offsetSel;
  logic [DATA_W-1:0] cfgData;
  logic [ADDR_W:0] wrPtrW, rdPtrW, wrPtrR, rdPtrR;
  logic aeFlag, afFlag;

  int total = 0, bad = 0;
  bit chkOn = 0, finished = 0;
  string phaseTag = "R9";

  always #4 wrClk = ~wrClk;
  initial begin #2; forever #4 rdClk = ~rdClk; end

  fill_threshold_flags #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fill_threshold_flags (
    .wrClk(wrClk), .rdClk(rdClk), .fullRstN(fullRstN), .partRstN(partRstN),
    .offsetSel(offsetSel), .parityMode(parityMode), .cfgLoad(cfgLoad),
    .cfgData(cfgData), .serialIn(serialIn),
    .wrPtrW(wrPtrW), .rdPtrW(rdPtrW), .wrPtrR(wrPtrR), .rdPtrR(rdPtrR),
    .aeFlag(aeFlag), .afFlag(afFlag)
  );

  // ---------------- reference model ----------------
  int mAe = 0, mAf = 0, mMode = 0, mPar = 0, mCnt = 0;
  bit afQ[$], aeQ[$];
  bit eAf = 0, eAe = 1;

  function automatic int presetOf(int s);
    case (s)
      0: return 8; 1: return 16; 2: return 64; 3: return 256;
      default: return 1024;
    endcase
  endfunction

  always @(posedge wrClk) begin
    bit raw;
    int v;
    raw = (((int'(wrPtrW) - int'(rdPtrW)) & PMASK) >= (DEPTH - mAf));
    if (!fullRstN || !partRstN) begin
      afQ = '{0, 0};
    end else begin
      afQ.push_back(raw);
      void'(afQ.pop_front());
    end
    eAf = afQ[0];
    if (!fullRstN) begin
      mMode = (offsetSel == 3'b101) ? 1 : (offsetSel >= 3'b110) ? 2 : 0;
      mAe = presetOf(int'(offsetSel));
      mAf = mAe;
      mPar = int'(parityMode);
      mCnt = 0;
    end else if (partRstN && cfgLoad) begin
      if (mMode == 1 && mCnt < 2 * ADDR_W) begin
        mAe = ((mAe << 1) | ((mAf >> (ADDR_W - 1)) & 1)) & OMASK;
        mAf = ((mAf << 1) | int'(serialIn)) & OMASK;
        mCnt++;
      end else if (mMode == 2 && mCnt < 2) begin
        v = int'(cfgData[ADDR_W-1:0]);
        if (mPar != 0) v = v & ~256;
        if (mCnt == 0) mAe = v; else mAf = v;
        mCnt++;
      end
    end
  end

  always @(posedge rdClk) begin
    bit raw;
    raw = (((int'(wrPtrR) - int'(rdPtrR)) & PMASK) <= mAe);
    if (!fullRstN || !partRstN) aeQ = '{1, 1};
    else begin
      aeQ.push_back(raw);
      void'(aeQ.pop_front());
    end
    eAe = aeQ[0];
  end

  task automatic check(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", phaseTag, what, act, exp, $time);
    end
  endtask

  always @(negedge wrClk) begin
    if (chkOn && !finished) begin
      check("afFlag", int'(afFlag), int'(eAf));
      check("aeFlag", int'(aeFlag), int'(eAe));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(int n);
    repeat (n) @(negedge wrClk);
  endtask

  task automatic setFill(int f, int base);
    wrPtrW = ADDR_W'(0) + (base + f) & PMASK;
    rdPtrW = base & PMASK;
    wrPtrR = (base + f) & PMASK;
    rdPtrR = base & PMASK;
  endtask

  task automatic holdFill(int f, int base);
    setFill(f, base);
    cyc(4);
  endtask

  task automatic sweep(int ae, int af, int base);
    for (int d = -1; d <= 1; d++) begin
      if (ae + d >= 0) holdFill(ae + d, base);
    end
    for (int d = -1; d <= 1; d++) begin
      if (DEPTH - af + d <= DEPTH) holdFill(DEPTH - af + d, base);
    end
    holdFill(0, base);
  endtask

  task automatic fullReset(int sel, int par);
    phaseTag = "R9";
    cfgLoad = 0;
    fullRstN = 0;
    offsetSel = 3'(sel);
    parityMode = par[0];
    cyc(3);
    check("reset aeFlag", int'(aeFlag), 1);
    check("reset afFlag", int'(afFlag), 0);
    fullRstN = 1;
    cyc(1);
  endtask

  task automatic parLoad(int value);
    cfgData = DATA_W'(value);
    cfgLoad = 1;
    cyc(1);
    cfgLoad = 0;
    cyc(1);
  endtask

  task automatic serShift(int value);
    for (int i = ADDR_W - 1; i >= 0; i--) begin
      serialIn = value[i];
      cfgLoad = 1;
      cyc(1);
    end
    cfgLoad = 0;
  endtask

  // ---------------- scenario ----------------
  initial begin
    fullRstN = 0; partRstN = 1; parityMode = 0; cfgLoad = 0; serialIn = 0;
    offsetSel = 0; cfgData = '0;
    wrPtrW = 0; rdPtrW = 0; wrPtrR = 0; rdPtrR = 0;
    cyc(2);
    chkOn = 1;

    // R1 presets, R3 / R4 thresholds
    for (int s = 0; s < 5; s++) begin
      fullReset(s, 0);
      phaseTag = "R1";
      check("preset af at fill 0", int'(afFlag), 0);
      phaseTag = "R3";
      sweep(presetOf(s), presetOf(s), 40);
      phaseTag = "R4";
      sweep(presetOf(s), presetOf(s), 1000);
    end

    // R2 pointer wraparound
    fullReset(2, 0);
    phaseTag = "R2";
    sweep(64, 64, PMASK - 3);
    sweep(64, 64, PMASK - 70);

    // R5 one-cycle blips around the thresholds
    phaseTag = "R5";
    for (int k = 0; k < 6; k++) begin
      setFill(64, 7); cyc(1);
      setFill(65, 7); cyc(1);
      setFill(DEPTH - 64, 7); cyc(1);
      setFill(DEPTH - 65, 7); cyc(2);
    end
    holdFill(0, 7);

    // R11 strobes in preset mode
    fullReset(1, 0);
    phaseTag = "R11";
    cfgData = DATA_W'(5);
    cfgLoad = 1; serialIn = 1;
    cyc(6);
    cfgLoad = 0;
    sweep(16, 16, 300);

    // R6 parallel load, third strobe ignored
    fullReset(6, 0);
    phaseTag = "R6";
    parLoad(300);
    parLoad(700);
    parLoad(5);
    sweep(300, 700, 9);

    // R7 parity mode clears bit 8
    fullReset(7, 1);
    phaseTag = "R7";
    parLoad(511);
    parLoad(261);
    sweep(255, 5, 123);

    // R8 serial load with extra bits ignored
    fullReset(5, 0);
    phaseTag = "R8";
    serShift(100);
    serShift(37);
    serShift(2047);
    sweep(100, 37, 2000);

    // R10 partial reset keeps offsets, strobes ignored
    phaseTag = "R10";
    setFill(1000, 0);
    partRstN = 0;
    cfgLoad = 1; serialIn = 1;
    cyc(3);
    check("partial reset aeFlag", int'(aeFlag), 1);
    check("partial reset afFlag", int'(afFlag), 0);
    partRstN = 1;
    cfgLoad = 0;
    cyc(1);
    sweep(100, 37, 77);

    // R10 partial reset in parallel mode keeps progress
    fullReset(6, 0);
    phaseTag = "R10";
    parLoad(50);
    partRstN = 0;
    cfgData = DATA_W'(3);
    cfgLoad = 1;
    cyc(3);
    cfgLoad = 0;
    partRstN = 1;
    cyc(1);
    parLoad(90);
    sweep(50, 90, 555);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1600000;
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule